// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is the central hazard controller for a small machine with four functional units: an integer unit, a floating-point adder, a floating-point multiplier and a floating-point divider. Decoded instructions arrive in program order on one issue port. Each instruction carries a unit class, an operation code, a destination register, two source registers and a tag. The controller admits at most one instruction per cycle. It then follows each instruction through four steps: admission to its unit, operand read, execution complete and result write.

Each unit has a per-unit record. The record holds the destination and source indices, the unit expected to produce each source, and per-source flags that mean "ready and not yet read". A table maps each register to the unit that will write it. From these the controller does three things. It holds back admission while the destination register is already claimed (WAW). It holds back the start of a unit until its sources are produced (RAW). It holds back a result write while another unit still has to read the old value (WAR).

Each unit is told when to begin by a one-cycle start pulse and reports back with a one-cycle done pulse. The controller grants the single register-file write port to one finished unit per cycle. The datapath, the register contents, branches and memory lie outside this block.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset all units are idle: `fu_busy`, `fu_rd`, `fu_cmp` and `fu_start` are zero, `wb_valid` is low, and `in_ready` is high.
- R2: At most one instruction is admitted per cycle, in the order presented. While the head instruction is held back, no later instruction is admitted.
- R3: An instruction whose destination register is claimed by an active unit is not admitted until that unit has written its result. Admission happens in a cycle after the write cycle.
- R4: An instruction is admitted only when the unit for its class is idle. The class code maps to units as 0 = integer, 1 = FP add, 2 = FP multiply, 3 = FP divide. On admission that unit becomes busy in the next cycle.
- R5: A unit whose source register is claimed by another active unit raises its start pulse only after the producing unit's result-write cycle.
- R6: With no pending producer for its sources, a unit pulses `fu_start` for exactly one cycle, in the cycle after admission.
- R7: A done pulse on a started unit marks it complete in the next cycle. With no conflict, the result write is granted there, so the write cycle equals the start cycle plus the latency plus one. The unit is idle after the write.
- R8: A unit does not write its result while another active unit still holds the same register as an unread source. The write comes at the earliest in the cycle after that reader's start pulse.
- R9: When several units could write in the same cycle, the one with the lowest class code is granted and the others wait. `wb_unit` reports the class code plus one; the value 0 means no unit.
- R10: On each granted write, `wb_tag` and `wb_dst` equal the tag and destination register of the instruction that was admitted to that unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction can be admitted this cycle |
| in_cls | input | 2 | Unit class (0 int, 1 add, 2 mul, 3 div) |
| in_op | input | 3 | Operation code forwarded to the unit |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_tag | input | 4 | Instruction tag |
| fu_start | output | 4 | One-cycle start per unit, bit index = class |
| fu_op | output | 12 | Operation code held per unit, 3 bits each |
| fu_done | input | 4 | One-cycle completion per unit |
| wb_valid | output | 1 | Register-file write granted |
| wb_unit | output | 3 | Granted unit (class + 1) |
| wb_dst | output | 5 | Register written |
| wb_tag | output | 4 | Tag of the writing instruction |
| fu_busy | output | 4 | Unit holds an instruction |
| fu_rd | output | 4 | Unit has read its operands |
| fu_cmp | output | 4 | Unit has finished execution |

## Verification
Four things are checked on every cycle. Admission never targets a busy unit and always makes that unit busy. A start pulse never lasts two cycles. A write grant only goes to a completed unit and frees it. The RAW, WAR and WAW orderings and the write-port priority depend on the order in which several units interact, so only the bench scenarios can show them: a long divide feeding an adder whose other source a multiplier overwrites, two units finishing in the same cycle, a second multiply behind a busy multiplier, and a reused destination register. The bench also checks the exact cycle offsets from admission to start to write against the unit latencies.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NFU    = 4;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int UID_W  = $clog2(NFU + 1);
    localparam int CLS_W  = $clog2(NFU);
    localparam int OP_W   = 3;
    localparam int TAG_W  = 4;

    typedef logic [UID_W-1:0] uid_t;

    typedef struct packed {
        logic              busy;
        logic              rd;
        logic              cmp;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  tag;
        logic [RIDX_W-1:0] fi;
        logic [RIDX_W-1:0] fj;
        logic [RIDX_W-1:0] fk;
        uid_t              qj;
        uid_t              qk;
        logic              rj;
        logic              rk;
    } fu_rec_t;

    typedef struct packed {
        fu_rec_t [NFU-1:0]          fu;
        logic [NREG-1:0][UID_W-1:0] rs;
    } sb_state_t;
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  logic                       in_valid,
    input  logic [CLS_W-1:0]           in_cls,
    input  logic [RIDX_W-1:0]          in_dst,
    input  logic [RIDX_W-1:0]          in_src1,
    input  logic [RIDX_W-1:0]          in_src2,
    input  logic [NFU-1:0]             busy,
    input  logic [NREG-1:0][UID_W-1:0] rs,
    input  logic                       wb_fire,
    input  uid_t                       wb_uid,
    output logic                       in_ready,
    output logic                       fire,
    output uid_t                       qj,
    output uid_t                       qk
);
    uid_t pj;
    uid_t pk;

    // unit free and destination not claimed
    assign in_ready = !busy[in_cls] && (rs[in_dst] == '0);
    assign fire     = in_valid && in_ready;

    // a producer that writes this very cycle no longer counts as pending
    assign pj = rs[in_src1];
    assign pk = rs[in_src2];
    assign qj = (wb_fire && pj == wb_uid) ? '0 : pj;
    assign qk = (wb_fire && pk == wb_uid) ? '0 : pk;
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  fu_rec_t [NFU-1:0] fu,
    output logic              wb_fire,
    output logic [CLS_W-1:0]  wb_idx
);
    logic [NFU-1:0] cand;

    for (genvar i = 0; i < NFU; i++) begin : g_war
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < NFU; j++) begin
                if (j != i && fu[j].busy &&
                    ((fu[j].fj == fu[i].fi && fu[j].rj) ||
                     (fu[j].fk == fu[i].fi && fu[j].rk))) begin
                    blk = 1'b1;
                end
            end
            cand[i] = fu[i].busy && fu[i].cmp && !blk;
        end
    end

    // lowest index wins the single write port
    always_comb begin
        wb_fire = |cand;
        wb_idx  = '0;
        for (int i = NFU - 1; i >= 0; i--) begin
            if (cand[i]) wb_idx = CLS_W'(i);
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [CLS_W-1:0]      in_cls,
    input  logic [OP_W-1:0]       in_op,
    input  logic [RIDX_W-1:0]     in_dst,
    input  logic [RIDX_W-1:0]     in_src1,
    input  logic [RIDX_W-1:0]     in_src2,
    input  logic [TAG_W-1:0]      in_tag,
    output logic [NFU-1:0]        fu_start,
    output logic [NFU*OP_W-1:0]   fu_op,
    input  logic [NFU-1:0]        fu_done,
    output logic                  wb_valid,
    output uid_t                  wb_unit,
    output logic [RIDX_W-1:0]     wb_dst,
    output logic [TAG_W-1:0]      wb_tag,
    output logic [NFU-1:0]        fu_busy,
    output logic [NFU-1:0]        fu_rd,
    output logic [NFU-1:0]        fu_cmp
);
    sb_state_t         q;
    sb_state_t         d;
    logic              iss_fire;
    uid_t              iss_qj;
    uid_t              iss_qk;
    logic              wb_fire;
    logic [CLS_W-1:0]  wb_idx;
    uid_t              wb_uid;

    for (genvar i = 0; i < NFU; i++) begin : g_out
        assign fu_busy[i]  = q.fu[i].busy;
        assign fu_rd[i]    = q.fu[i].rd;
        assign fu_cmp[i]   = q.fu[i].cmp;
        assign fu_start[i] = q.fu[i].busy && !q.fu[i].rd && q.fu[i].rj && q.fu[i].rk;
        assign fu_op[i*OP_W +: OP_W] = q.fu[i].op;
    end

    sb_issue_ctl u_issue (
        .in_valid (in_valid),
        .in_cls   (in_cls),
        .in_dst   (in_dst),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .busy     (fu_busy),
        .rs       (q.rs),
        .wb_fire  (wb_fire),
        .wb_uid   (wb_uid),
        .in_ready (in_ready),
        .fire     (iss_fire),
        .qj       (iss_qj),
        .qk       (iss_qk)
    );

    sb_wb_arb u_arb (
        .fu      (q.fu),
        .wb_fire (wb_fire),
        .wb_idx  (wb_idx)
    );

    assign wb_uid   = uid_t'(wb_idx) + uid_t'(1);
    assign wb_valid = wb_fire;
    assign wb_unit  = wb_fire ? wb_uid : '0;
    assign wb_dst   = q.fu[wb_idx].fi;
    assign wb_tag   = q.fu[wb_idx].tag;

    always_comb begin
        d = q;
        // operand read and completion
        for (int i = 0; i < NFU; i++) begin
            if (fu_start[i]) begin
                d.fu[i].rd = 1'b1;
                d.fu[i].rj = 1'b0;
                d.fu[i].rk = 1'b0;
            end
            if (fu_done[i] && q.fu[i].rd && !q.fu[i].cmp) begin
                d.fu[i].cmp = 1'b1;
            end
        end
        // result write: free the unit, release waiting readers
        if (wb_fire) begin
            d.fu[wb_idx].busy = 1'b0;
            d.fu[wb_idx].rd   = 1'b0;
            d.fu[wb_idx].cmp  = 1'b0;
            d.rs[q.fu[wb_idx].fi] = '0;
            for (int i = 0; i < NFU; i++) begin
                if (q.fu[i].busy && q.fu[i].qj == wb_uid) begin
                    d.fu[i].qj = '0;
                    d.fu[i].rj = 1'b1;
                end
                if (q.fu[i].busy && q.fu[i].qk == wb_uid) begin
                    d.fu[i].qk = '0;
                    d.fu[i].rk = 1'b1;
                end
            end
        end
        // admission
        if (iss_fire) begin
            d.fu[in_cls].busy = 1'b1;
            d.fu[in_cls].rd   = 1'b0;
            d.fu[in_cls].cmp  = 1'b0;
            d.fu[in_cls].op   = in_op;
            d.fu[in_cls].tag  = in_tag;
            d.fu[in_cls].fi   = in_dst;
            d.fu[in_cls].fj   = in_src1;
            d.fu[in_cls].fk   = in_src2;
            d.fu[in_cls].qj   = iss_qj;
            d.fu[in_cls].qk   = iss_qk;
            d.fu[in_cls].rj   = (iss_qj == '0);
            d.fu[in_cls].rk   = (iss_qk == '0);
            d.rs[in_dst]      = uid_t'(in_cls) + uid_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sb_checks.sv
module sb_checks
    import sb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CLS_W-1:0] in_cls,
    input logic [NFU-1:0]   fu_busy,
    input logic [NFU-1:0]   fu_start,
    input logic [NFU-1:0]   fu_cmp,
    input logic             wb_valid,
    input uid_t             wb_unit
);
    logic [NFU-1:0] wb_oh;

    always_comb begin
        wb_oh = '0;
        for (int i = 0; i < NFU; i++) begin
            if (wb_valid && wb_unit == uid_t'(i + 1)) wb_oh[i] = 1'b1;
        end
    end

    p_issue_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !fu_busy[in_cls]);

    p_issue_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> fu_busy[$past(in_cls)]);

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|fu_start) |=> ((fu_start & $past(fu_start)) == '0));

    p_wb_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_oh != '0 && (wb_oh & ~fu_cmp) == '0));

    p_wb_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> ((fu_busy & $past(wb_oh)) == '0));
endmodule

bind sb_scoreboard sb_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_cls   (in_cls),
    .fu_busy  (fu_busy),
    .fu_start (fu_start),
    .fu_cmp   (fu_cmp),
    .wb_valid (wb_valid),
    .wb_unit  (wb_unit)
);

// File: tb/tb_sb_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_scoreboard;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [CLS_W-1:0] in_cls = '0;
    logic [OP_W-1:0] in_op = '0;
    logic [RIDX_W-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [NFU-1:0] fu_start, fu_busy, fu_rd, fu_cmp;
    logic [NFU-1:0] fu_done = '0;
    logic [NFU*OP_W-1:0] fu_op;
    logic wb_valid;
    uid_t wb_unit;
    logic [RIDX_W-1:0] wb_dst;
    logic [TAG_W-1:0] wb_tag;

    always #2.5 clk = ~clk;

    sb_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1),
        .in_src2(in_src2), .in_tag(in_tag), .fu_start(fu_start), .fu_op(fu_op),
        .fu_done(fu_done), .wb_valid(wb_valid), .wb_unit(wb_unit),
        .wb_dst(wb_dst), .wb_tag(wb_tag), .fu_busy(fu_busy), .fu_rd(fu_rd),
        .fu_cmp(fu_cmp)
    );

    int lat [NFU] = '{1, 2, 10, 40};
    int cnt [NFU] = '{0, 0, 0, 0};
    int utag[NFU] = '{0, 0, 0, 0};
    int iss [16];
    int st  [16];
    int wbc [16];
    int eq_tag[$];
    int eq_dst[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk_eq(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic chk_gt(string rq, int act, int bound);
        n_chk++;
        if (!(act > bound)) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected greater than %0d", rq, act, bound);
        end
    endtask

    task automatic expect_wb(int tag, int dst);
        eq_tag.push_back(tag);
        eq_dst.push_back(dst);
    endtask

    // called after posedge + 1; returns after posedge + 1 of the cycle following admission
    task automatic issue(int tag, int cls, int dst, int s1, int s2);
        in_valid = 1'b1;
        in_tag = TAG_W'(tag);
        in_cls = CLS_W'(cls);
        in_op = OP_W'(tag);
        in_dst = RIDX_W'(dst);
        in_src1 = RIDX_W'(s1);
        in_src2 = RIDX_W'(s2);
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (fu_busy != '0);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // unit latency models
    initial forever begin
        @(posedge clk); #1;
        for (int u = 0; u < NFU; u++) begin
            fu_done[u] = 1'b0;
            if (cnt[u] > 0) begin
                cnt[u]--;
                if (cnt[u] == 0) fu_done[u] = 1'b1;
            end
        end
    end

    // monitor: log stage cycles and compare each write against the queue
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            for (int u = 0; u < NFU; u++) begin
                if (fu_start[u]) begin
                    st[utag[u]] = cyc;
                    cnt[u] = lat[u];
                end
            end
            if (in_valid && in_ready) begin
                iss[in_tag] = cyc;
                utag[in_cls] = int'(in_tag);
            end
            if (wb_valid) begin
                wbc[wb_tag] = cyc;
                if (eq_tag.size() == 0) begin
                    chk_eq("R10 unexpected write tag", int'(wb_tag), -1);
                end else begin
                    chk_eq("R10 write tag", int'(wb_tag), eq_tag.pop_front());
                    chk_eq("R10 write dst", int'(wb_dst), eq_dst.pop_front());
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            iss[i] = -1; st[i] = -1; wbc[i] = -1;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 busy", int'(fu_busy), 0);
        chk_eq("R1 start", int'(fu_start), 0);
        chk_eq("R1 read", int'(fu_rd), 0);
        chk_eq("R1 complete", int'(fu_cmp), 0);
        chk_eq("R1 wb_valid", int'(wb_valid), 0);
        chk_eq("R1 in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        // A: four independent instructions back to back
        expect_wb(1, 1); expect_wb(2, 2); expect_wb(3, 3); expect_wb(4, 4);
        issue(1, 0, 1, 20, 21);
        issue(2, 1, 2, 20, 21);
        issue(3, 2, 3, 20, 21);
        issue(4, 3, 4, 20, 21);
        wait_idle();
        chk_eq("R2 one per cycle", iss[2] - iss[1], 1);
        chk_eq("R2 one per cycle", iss[4] - iss[3], 1);
        for (int t = 1; t <= 4; t++) begin
            chk_eq("R6 start after issue", st[t] - iss[t], 1);
            chk_eq("R7 write after start", wbc[t] - st[t], lat[t-1] + 1);
        end

        // B: add and int finish together, int has priority
        expect_wb(6, 6); expect_wb(5, 5);
        issue(5, 1, 5, 20, 21);
        issue(6, 0, 6, 20, 21);
        wait_idle();
        chk_eq("R9 int writes first", wbc[5] - wbc[6], 1);

        // C: second multiply waits for the multiplier, integer op queued behind it
        expect_wb(7, 7); expect_wb(9, 9); expect_wb(8, 8);
        issue(7, 2, 7, 20, 21);
        issue(8, 2, 8, 20, 21);
        issue(9, 0, 9, 20, 21);
        wait_idle();
        chk_gt("R4 unit busy holds issue", iss[8], wbc[7]);
        chk_gt("R2 head blocks later", iss[9], wbc[7]);
        chk_eq("R2 in order", iss[9] - iss[8], 1);

        // D: destination reuse
        expect_wb(10, 10); expect_wb(11, 10);
        issue(10, 3, 10, 20, 21);
        issue(11, 0, 10, 1, 2);
        wait_idle();
        chk_gt("R3 WAW holds issue", iss[11], wbc[10]);

        // E: RAW on divide result, WAR on multiplier destination
        expect_wb(12, 11); expect_wb(14, 13); expect_wb(13, 12);
        issue(12, 3, 11, 1, 2);
        issue(13, 1, 12, 11, 13);
        issue(14, 2, 13, 2, 3);
        wait_idle();
        chk_gt("R5 RAW start after producer write", st[13], wbc[12]);
        chk_gt("R8 WAR write after reader start", wbc[14], st[13]);
        chk_gt("R8 WAR write stalled", wbc[14], st[14] + lat[2] + 1);

        chk_eq("R10 queue drained", eq_tag.size(), 0);
        chk_eq("R1 idle at end", int'(fu_busy), 0);
        finish_run();
    end
endmodule